// File: doc/BRIEF.md
# Serial Audio Port with Clock Master

This block receives two-channel serial audio and turns it into parallel 16-bit left and right samples. It works in one of two roles. As clock master it creates the frame clock and the bit clock itself from the internal clock, through a programmable divider. As clock slave it follows a frame clock and a bit clock supplied from outside. In both roles the same receiver, running on the internal clock, samples the serial data and assembles one word per channel. A one-cycle strobe marks each completed left/right pair.

The framing polarity and the bit-clock sampling edge can each be inverted. The master divider has two modes. In integer mode the frame period is a whole number of internal clocks, set by the low divider byte. In fractional mode the full divider value feeds a phase accumulator, so rates that do not divide the internal clock evenly are reachable. Configuration is meant to be set while the block is held in reset.

Top module: `serial_audio_port`

## Requirements
- R1: With `master_i`=1 the block drives `frame_o` and `bclk_o` from its own divider and ignores `frame_ext_i` and `bclk_ext_i`. With `master_i`=0 it receives on `frame_ext_i`/`bclk_ext_i` and holds `frame_o` and `bclk_o` at 0.
- R2: With `frame_inv_i`=0 a word sampled while the frame clock is low is the left sample and one sampled while it is high is the right sample. With `frame_inv_i`=1 the two levels swap; in master mode the generated frame clock is inverted to match.
- R3: With `bclk_inv_i`=0 serial data is sampled on the rising bit-clock edge; with `bclk_inv_i`=1 it is sampled on the falling edge. In master mode `bclk_o` is inverted to match.
- R4: In integer mode (`int_mode_i`=1) the master frame period is exactly 16×L internal clocks, where L is `frame_div_i[7:0]`. Bits [14:8] have no effect. Values of L below 4 act as 4.
- R5: In fractional mode (`int_mode_i`=0) a 15-bit accumulator adds `frame_div_i` every internal clock. Each carry out is one half bit-clock period, giving a frame period of 2^21 / `frame_div_i` internal clocks.
- R6: In master mode each frame period holds exactly 32 bit-clock periods. The frame clock changes only together with a bit-clock edge of the non-sampling direction.
- R7: Each word is 16 bits, MSB first. Its last bit is the one sampled on the first sampling edge after the frame clock changes level, which gives a one-bit delay.
- R8: When a right word completes and a left word has completed since the previous strobe, `valid_o` is high for exactly one clock. `left_o` and `right_o` take the pair at that point and hold it until the next strobe. `valid_o` rises on the third internal clock edge after the sampling edge appears at the bit-clock pin (or at `bclk_o` in master mode).
- R9: While `rst_n` is low, `valid_o`, `left_o` and `right_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial audio data |
| frame_ext_i | input | 1 | External frame clock (slave role) |
| bclk_ext_i | input | 1 | External bit clock (slave role) |
| master_i | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| frame_inv_i | input | 1 | Frame clock polarity invert |
| bclk_inv_i | input | 1 | Bit clock sampling edge invert |
| int_mode_i | input | 1 | 1 = integer divider, 0 = fractional accumulator |
| frame_div_i | input | 15 | Frame divider value |
| frame_o | output | 1 | Generated frame clock (0 in slave role) |
| bclk_o | output | 1 | Generated bit clock (0 in slave role) |
| left_o | output | 16 | Last completed left sample |
| right_o | output | 16 | Last completed right sample |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The assertions assume the configuration inputs stay constant except while `rst_n` is low, and the stimulus reprograms them only inside a reset pulse. They also assume that data and frame level change only on the non-sampling bit-clock edge. The bench transmitter drives the next bit only on that edge, whether the clocks come from the block or from the bench itself. External clock levels in slave runs last at least two internal clocks, so the synchronizer never misses an edge. Master runs keep the divider inside its legal range, except for the deliberate low values that check clamping.

// File: rtl/serial_audio_port.sv
module serial_audio_port #(
  parameter int SAMPLE_W = 16,
  parameter int DIV_W    = 15,
  parameter int INT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sdata_i,
  input  logic                frame_ext_i,
  input  logic                bclk_ext_i,
  input  logic                master_i,
  input  logic                frame_inv_i,
  input  logic                bclk_inv_i,
  input  logic                int_mode_i,
  input  logic [DIV_W-1:0]    frame_div_i,
  output logic                frame_o,
  output logic                bclk_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int HALF_BITS = 4 * SAMPLE_W;
  localparam int PH_W      = $clog2(HALF_BITS);
  localparam int MIN_L     = HALF_BITS / 16;
  localparam int SUM_W     = DIV_W + 1;

  // master clock generation
  logic [DIV_W-1:0] acc;
  logic [PH_W-1:0]  ph;
  logic [INT_W-1:0] lsel;
  logic [SUM_W-1:0] period, int_sum, frac_sum;
  logic             tick, gen_f, gen_b;

  assign lsel     = (frame_div_i[INT_W-1:0] < INT_W'(MIN_L)) ? INT_W'(MIN_L) : frame_div_i[INT_W-1:0];
  assign period   = SUM_W'(lsel) << 4;
  assign int_sum  = SUM_W'(acc) + SUM_W'(HALF_BITS);
  assign frac_sum = SUM_W'(acc) + SUM_W'(frame_div_i);
  assign tick     = int_mode_i ? (int_sum >= period) : frac_sum[DIV_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc <= '0;
      ph  <= '0;
    end else if (!master_i) begin
      acc <= '0;
      ph  <= '0;
    end else begin
      if (int_mode_i) acc <= tick ? DIV_W'(int_sum - period) : DIV_W'(int_sum);
      else            acc <= frac_sum[DIV_W-1:0];
      if (tick) ph <= ph + 1'b1;
    end

  assign gen_f   = ph[PH_W-1] ^ frame_inv_i;
  assign gen_b   = ph[0] ^ bclk_inv_i;
  assign frame_o = master_i & gen_f;
  assign bclk_o  = master_i & gen_b;

  // receiver: synchronize the selected clocks and data
  logic [1:0] fs, ds;
  logic [2:0] bs;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs <= '0;
      bs <= '0;
      ds <= '0;
    end else begin
      fs <= {fs[0], master_i ? gen_f : frame_ext_i};
      bs <= {bs[1:0], master_i ? gen_b : bclk_ext_i};
      ds <= {ds[0], sdata_i};
    end

  logic                samp, slot_end, left_slot, started, fp, have_left;
  logic [SAMPLE_W-2:0] sr;
  logic [SAMPLE_W-1:0] word, left_hold;

  assign samp      = (bs[1] != bs[2]) && (bs[1] != bclk_inv_i);
  assign word      = {sr, ds[1]};
  assign slot_end  = samp && started && (fs[1] != fp);
  assign left_slot = (fp == frame_inv_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr        <= '0;
      started   <= 1'b0;
      fp        <= 1'b0;
      have_left <= 1'b0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (samp) begin
        sr      <= word[SAMPLE_W-2:0];
        started <= 1'b1;
        fp      <= fs[1];
      end
      if (slot_end) begin
        if (left_slot) begin
          left_hold <= word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o    <= left_hold;
          right_o   <= word;
          valid_o   <= 1'b1;
          have_left <= 1'b0;
        end
      end
    end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R2
  left_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && left_slot) |=> !valid_o);

  // R6
  clk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && $past(master_i) && $stable(frame_inv_i) && $stable(bclk_inv_i) && !$stable(frame_o))
      |-> (!$stable(bclk_o) && bclk_o == bclk_inv_i));

  // R4
  int_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && int_mode_i && SUM_W'(acc) < period)
      |=> (!$stable(frame_div_i) || !$stable(int_mode_i) || !master_i || SUM_W'(acc) < period));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!valid_o && left_o == '0 && right_o == '0));
endmodule

// File: tb/serial_audio_port_tb_top.sv
module serial_audio_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic sdata = 1'b0, fext = 1'b0, bext = 1'b0;
  logic master = 1'b0, finv = 1'b0, binv = 1'b0, intm = 1'b0;
  logic [14:0] div = '0;
  logic frame_o, bclk_o, valid_o;
  logic [15:0] left_o, right_o;

  serial_audio_port dut_i (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata), .frame_ext_i(fext), .bclk_ext_i(bext),
    .master_i(master), .frame_inv_i(finv), .bclk_inv_i(binv), .int_mode_i(intm),
    .frame_div_i(div), .frame_o(frame_o), .bclk_o(bclk_o),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, nv = 0;
  int ev_cyc[$];
  logic [15:0] ev_l[$], ev_r[$];
  logic rb, rf, pb, pf;
  logic started, fp, hl;
  logic [15:0] hist, lw, txw, lfsr = 16'hACE1;
  logic txf;
  int txi, seq, half, hcnt, last_fr, brise, exp_per;
  logic [5:0] hp;
  string ptag, dtag;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    bit ev;
    logic [15:0] w;
    @(posedge clk); #1;
    cyc++;
    ev = (ev_cyc.size() > 0 && ev_cyc[0] == cyc);
    chk(valid_o == ev, "R8", "valid_o", valid_o, ev);
    if (ev) begin
      nv++;
      chk(left_o == ev_l[0], dtag, "left_o", left_o, ev_l[0]);
      chk(right_o == ev_r[0], dtag, "right_o", right_o, ev_r[0]);
      void'(ev_cyc.pop_front()); void'(ev_l.pop_front()); void'(ev_r.pop_front());
    end
    if (master) begin
      rb = bclk_o;
      rf = frame_o;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fext = lfsr[0];
      bext = lfsr[3];
      if (rf && !pf) begin
        if (last_fr >= 0) begin
          chk(cyc - last_fr == exp_per, ptag, "frame period", cyc - last_fr, exp_per);
          chk(brise == 32, "R6", "bit clocks per frame", brise, 32);
        end
        last_fr = cyc;
        brise = 0;
      end
      if (rb && !pb) brise++;
    end else begin
      chk(frame_o == 1'b0 && bclk_o == 1'b0, "R1", "slave clock outputs", {frame_o, bclk_o}, 0);
      hcnt++;
      if (hcnt == half) begin
        hcnt = 0;
        hp = hp + 1'b1;
      end
      rb = hp[0] ^ binv;
      rf = hp[5] ^ finv;
      bext = rb;
      fext = rf;
    end
    if (rb != pb && rb != binv) begin
      w = {hist[14:0], sdata};
      if (started && rf != fp) begin
        if (fp == finv) begin
          lw = w;
          hl = 1'b1;
        end else if (hl) begin
          ev_cyc.push_back(cyc + 3); ev_l.push_back(lw); ev_r.push_back(w);
          hl = 1'b0;
        end
      end
      started = 1'b1;
      fp = rf;
      hist = w;
    end else if (rb != pb) begin
      if (rf != txf) begin
        txf = rf;
        sdata = txw[0];
        seq++;
        txw = 16'hA5C3 ^ 16'(seq * 'h3B17);
        txi = 15;
      end else if (txi > 0) begin
        sdata = txw[txi];
        txi--;
      end else begin
        sdata = 1'b0;
      end
    end
    pb = rb;
    pf = rf;
  endtask

  task automatic run(input bit m, input bit fi, input bit bi, input bit im, input logic [14:0] d,
                     input int hb, input int per, input string pt, input string dt, input int n);
    rst_n = 1'b0;
    master = m; finv = fi; binv = bi; intm = im; div = d;
    half = hb; hcnt = 0; hp = '0; sdata = 1'b0;
    fext = m ? 1'b0 : fi;
    bext = m ? 1'b0 : bi;
    repeat (3) @(posedge clk);
    #1;
    // R9 outputs cleared during reset
    chk(valid_o == 1'b0 && left_o == 16'h0 && right_o == 16'h0, "R9", "reset outputs", {valid_o, left_o, right_o}, 0);
    pb = bi; pf = fi; started = 1'b0; fp = 1'b0; hl = 1'b0; hist = '0; lw = '0;
    txf = fi; txw = '0; txi = 0;
    last_fr = -1; brise = 0; exp_per = per; ptag = pt; dtag = dt; nv = 0;
    ev_cyc.delete(); ev_l.delete(); ev_r.delete();
    rst_n = 1'b1;
    repeat (n) step();
    chk(nv >= 4, "R8", "pairs received", nv, 4);
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    // R4 integer mode, L=8 -> 128 clocks; R7 word format
    run(1, 0, 0, 1, 15'h0008, 1, 128, "R4", "R7", 2000);
    // R4 upper bits ignored (L=6 -> 96); R2 frame polarity swapped
    run(1, 1, 0, 1, 15'h7F06, 1, 96, "R4", "R2", 2000);
    // R4 clamp L=2 -> 64; R3 falling-edge sampling
    run(1, 0, 1, 1, 15'h0002, 1, 64, "R4", "R3", 1500);
    // R5 fractional 16384 -> 128; R1 external clock noise ignored in master role
    run(1, 1, 1, 0, 15'h4000, 1, 128, "R5", "R1", 2000);
    // R5 fractional 4096 -> 512
    run(1, 0, 0, 0, 15'h1000, 1, 512, "R5", "R7", 4000);
    // R1 slave role with external clocks
    run(0, 0, 0, 1, 15'h0008, 3, 0, "R1", "R1", 3000);
    // R2 slave with inverted frame and bit clock
    run(0, 1, 1, 0, 15'h0000, 2, 0, "R2", "R2", 3000);
    // R3 slave, falling-edge sampling
    run(0, 0, 1, 0, 15'h0000, 5, 0, "R3", "R3", 3000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule